// File: doc/BRIEF.md
# Serial Byte-Stream Cipher State with Row Rotation

This block holds the 4x4 byte state of a byte-serial block cipher datapath. It also performs the row-rotation step of that cipher in both directions. Bytes enter and leave through one 8-bit port. The state is arranged as a single shift chain in column-major order: chain index = row + 4 * column. Each load/unload strobe moves the whole chain one position. A new byte enters at index 15 while the byte at index 0 is presented at the output. Loading and unloading can therefore overlap.

A start pulse begins a rotation pass that lasts three clock edges. On each of these edges, every row whose enable is set rotates one byte to the left. Row 0 is never enabled. The enable pattern gives the forward rotation (row r moves left by r) or the inverse rotation (row r moves left by 4 - r). Only one left-rotate path per cell is needed, because the direction is expressed entirely through which rows are enabled on which edge.

The controller has three named states:
- `ST_IDLE` waits. Start moves it to `ST_ROTATE` (the accept transition). The load/unload strobe shifts the chain but keeps the state in `ST_IDLE`.
- `ST_ROTATE` stays in place for three edges while a step counter advances. After the third step it moves to `ST_FINISH` (the last-step transition).
- `ST_FINISH` raises the done flag and returns to `ST_IDLE` on the next edge (the release transition).

Top module: `aes_state_rotator`

## Requirements
- R1: After reset, done is low and all 16 state bytes are zero, so sixteen unload strobes return sixteen zero bytes.
- R2: In `ST_IDLE`, each clock edge with shift_en high and start low moves the chain one position. The byte at chain index k+1 moves to index k, byte_in enters index 15, and byte_out always shows index 0. Chain index is row + 4 * column. With both strobes low in `ST_IDLE`, the state holds.
- R3: A pass started with inverse low leaves out[r][c] = in[r][(c + r) mod 4].
- R4: A pass started with inverse high leaves out[r][c] = in[r][(c - r) mod 4].
- R5: done is high for exactly one cycle. That cycle follows the third clock edge after the edge that accepts start, and the rotation takes exactly those three edges.
- R6: From the accepting edge until done falls, further start pulses and shift_en are ignored. Neither alters the state or the timing.
- R7: The direction is sampled only on the accepting edge. Changes on inverse later in the pass have no effect on the result.
- R8: Row 0 is never changed by a pass. On each rotating edge, an enabled row moves one byte left. Forward passes enable row r on steps 0 to r-1. Inverse passes enable row r on steps 0 to 3-r.
- R9: An inverse pass applied after a forward pass restores the originally loaded state.
- R10: If start and shift_en are both high in `ST_IDLE`, start wins. The pass begins and no serial shift occurs on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | 8 | Serial byte entering chain index 15 |
| shift_en | input | 1 | Load/unload strobe, one chain position per edge |
| start | input | 1 | Begins a rotation pass when idle |
| inverse | input | 1 | Direction: 0 forward, 1 inverse; sampled at start |
| byte_out | output | 8 | Byte at chain index 0 |
| done | output | 1 | One-cycle flag after the third rotation edge |

## Verification
The assertions take for granted that start, shift_en, inverse and byte_in are synchronous to clk and never unknown once reset is released. They also assume reset is applied before the first use, so the step counter and direction register start from a defined value. The bench changes every input on the falling edge and holds strobes steady across each rising edge. During a pass it deliberately raises start, shift_en and a flipped direction, to exercise the ignore rules without breaking those input assumptions.

// File: rtl/aes_rot_pkg.sv
package aes_rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROTATE = 2'd1,
        ST_FINISH = 2'd2
    } rot_state_e;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } rot_dir_e;

endpackage

// File: rtl/aes_rot_ctrl.sv
module aes_rot_ctrl
    import aes_rot_pkg::*;
#(
    parameter int NUM_ROWS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                shift_en,
    input  logic                inverse,
    output logic                busy,
    output logic                rotating,
    output logic                load_shift,
    output logic                done,
    output logic [NUM_ROWS-1:0] row_en
);

    localparam int STEP_W    = $clog2(NUM_ROWS);
    localparam int LAST_STEP = NUM_ROWS - 2;

    rot_state_e        state_q, state_d;
    rot_dir_e          dir_q, dir_d;
    logic [STEP_W-1:0] step_q, step_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_FWD;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            step_q  <= step_d;
        end
    end

    // transitions: accept, last-step, release
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_ROTATE;
                    step_d  = '0;
                    dir_d   = inverse ? DIR_INV : DIR_FWD;
                end
            end
            ST_ROTATE: begin
                if (step_q == STEP_W'(LAST_STEP)) begin
                    state_d = ST_FINISH;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        busy       = 1'b0;
        rotating   = 1'b0;
        load_shift = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_shift = shift_en && !start;
            ST_ROTATE: begin
                busy     = 1'b1;
                rotating = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // per-row gated enables: the rotation amount is set by how many steps a row is enabled
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row_en
        if (r == 0) begin : g_fixed
            assign row_en[r] = 1'b0;
        end else begin : g_moving
            assign row_en[r] = rotating &&
                ((dir_q == DIR_FWD) ? (step_q < STEP_W'(r))
                                    : (step_q < STEP_W'(NUM_ROWS - r)));
        end
    end

endmodule

// File: rtl/aes_state_array.sv
module aes_state_array #(
    parameter int BYTE_W   = 8,
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_shift,
    input  logic [NUM_ROWS-1:0]                   row_en,
    input  logic [BYTE_W-1:0]                     byte_in,
    output logic [BYTE_W-1:0]                     byte_out,
    output logic [NUM_ROWS*NUM_COLS*BYTE_W-1:0]   cells_flat
);

    localparam int NUM_CELLS = NUM_ROWS * NUM_COLS;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            localparam int IDX     = r + NUM_ROWS * c;
            localparam int ROT_IDX = r + NUM_ROWS * ((c + 1) % NUM_COLS);

            logic [BYTE_W-1:0] q;
            logic [BYTE_W-1:0] ser_src;

            if (IDX == NUM_CELLS - 1) begin : g_tail
                assign ser_src = byte_in;
            end else begin : g_link
                assign ser_src = cells_flat[(IDX + 1) * BYTE_W +: BYTE_W];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (load_shift) begin
                    q <= ser_src;
                end else if (row_en[r]) begin
                    q <= cells_flat[ROT_IDX * BYTE_W +: BYTE_W];
                end
            end

            assign cells_flat[IDX * BYTE_W +: BYTE_W] = q;
        end
    end

    assign byte_out = cells_flat[BYTE_W-1:0];

endmodule

// File: rtl/aes_state_rotator.sv
module aes_state_rotator #(
    parameter int BYTE_W   = 8,
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              shift_en,
    input  logic              start,
    input  logic              inverse,
    output logic [BYTE_W-1:0] byte_out,
    output logic              done
);

    localparam int STATE_BITS = NUM_ROWS * NUM_COLS * BYTE_W;

    logic                  busy;
    logic                  rotating;
    logic                  load_shift;
    logic [NUM_ROWS-1:0]   row_en;
    logic [STATE_BITS-1:0] cells_flat;

    aes_rot_ctrl #(
        .NUM_ROWS (NUM_ROWS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .shift_en   (shift_en),
        .inverse    (inverse),
        .busy       (busy),
        .rotating   (rotating),
        .load_shift (load_shift),
        .done       (done),
        .row_en     (row_en)
    );

    aes_state_array #(
        .BYTE_W   (BYTE_W),
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_shift (load_shift),
        .row_en     (row_en),
        .byte_in    (byte_in),
        .byte_out   (byte_out),
        .cells_flat (cells_flat)
    );

endmodule

// File: rtl/aes_state_rotator_chk.sv
module aes_state_rotator_chk #(
    parameter int BYTE_W   = 8,
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                start,
    input logic                                shift_en,
    input logic                                done,
    input logic                                busy,
    input logic                                rotating,
    input logic [NUM_ROWS*NUM_COLS*BYTE_W-1:0] cells_flat
);

    logic [NUM_COLS*BYTE_W-1:0] row0;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_row0
        assign row0[c*BYTE_W +: BYTE_W] = cells_flat[(c*NUM_ROWS)*BYTE_W +: BYTE_W];
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_three_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rotating, 1) && $past(rotating, 3) && !$past(busy, 4)));

    assert_start_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> rotating);

    assert_finish_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rotating) |=> $stable(cells_flat));

    assert_row0_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rotating |=> $stable(row0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !shift_en) |=> $stable(cells_flat));

    assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> $stable(cells_flat));

endmodule

bind aes_state_rotator aes_state_rotator_chk #(
    .BYTE_W   (BYTE_W),
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .shift_en   (shift_en),
    .done       (done),
    .busy       (busy),
    .rotating   (rotating),
    .cells_flat (cells_flat)
);

// File: tb/aes_state_rotator_bench.sv
module aes_state_rotator_bench;

    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic       shift_en = 1'b0;
    logic       start = 1'b0;
    logic       inverse = 1'b0;
    logic [7:0] byte_out;
    logic       done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] stim [NB];
    logic [7:0] expv [NB];

    always #2 clk = ~clk;

    aes_state_rotator u_aes_state_rotator (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .shift_en (shift_en),
        .start    (start),
        .inverse  (inverse),
        .byte_out (byte_out),
        .done     (done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // software model: out[r][c] = in[r][(c +/- r) mod 4], index = r + 4c
    task automatic model(input bit inv);
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                int sc;
                sc = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
                expv[r + 4*c] = stim[r + 4*sc];
            end
        end
    endtask

    task automatic load_stim();
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            byte_in  = stim[i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
        byte_in  = '0;
    endtask

    task automatic unload_cmp(input string req);
        for (int i = 0; i < NB; i++) begin
            chk(req, byte_out, expv[i]);
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    // called on a falling edge; leaves on a falling edge with the block idle
    task automatic run_op(input bit inv, input bit disturb, input bit with_shift);
        start    = 1'b1;
        inverse  = inv;
        shift_en = with_shift;
        byte_in  = 8'hFF;
        for (int j = 1; j <= 5; j++) begin
            @(negedge clk);
            if (j == 1) begin
                start    = disturb;
                shift_en = disturb;
                byte_in  = 8'hA5;
                inverse  = disturb ? !inv : inv;
            end
            if (j == 3) begin
                start    = 1'b0;
                shift_en = 1'b0;
                byte_in  = '0;
            end
            chk(disturb ? "R5/R6" : "R5", {7'd0, done}, {7'd0, (j == 4)});
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {7'd0, done}, 8'd0);
        for (int i = 0; i < NB; i++) expv[i] = '0;
        unload_cmp("R1");

        // serial pass-through, chain order only
        for (int i = 0; i < NB; i++) stim[i] = 8'(i * 17 + 3);
        load_stim();
        for (int i = 0; i < NB; i++) expv[i] = stim[i];
        unload_cmp("R2");

        // sweep: distinct patterns, both directions, with and without disturbance
        for (int v = 0; v < 64; v++) begin
            bit inv;
            bit dis;
            inv = v[0];
            dis = v[1];
            for (int i = 0; i < NB; i++)
                stim[i] = (v < 4) ? 8'(i) : 8'(v * 37 + i * 13 + (v >> 2) * i * i);
            load_stim();
            run_op(inv, dis, 1'b0);
            model(inv);
            if (dis)      unload_cmp(inv ? "R4/R7" : "R3/R7");
            else if (v < 4) unload_cmp("R8");
            else          unload_cmp(inv ? "R4" : "R3");
        end

        // inverse undoes forward
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < NB; i++) stim[i] = 8'(v * 91 + i * 29 + 5);
            load_stim();
            run_op(1'b0, 1'b0, 1'b0);
            run_op(1'b1, v[0], 1'b0);
            for (int i = 0; i < NB; i++) expv[i] = stim[i];
            unload_cmp("R9");
        end

        // start and strobe together in idle
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < NB; i++) stim[i] = 8'(v * 53 + i * 7 + 1);
            load_stim();
            run_op(v[0], 1'b0, 1'b1);
            model(v[0]);
            unload_cmp("R10");
        end

        report();
    end

endmodule